// File: doc/BRIEF.md
# Phase-Multiplexed Memory Link Bridge

This block is the memory-side end of a chip-to-chip link that carries fetch requests in and fetch responses out over two unidirectional 8-bit buses. There are no framing strobes. Each end keeps a 3-bit phase counter that is cleared by the same synchronous reset. Both counters then advance in step, so each byte's meaning comes from its slot in a fixed 8-clock frame.

On the receive side, the block collects one byte per phase: a flag byte, a 24-bit instruction address and a 24-bit data address. It hands the complete request to the memory logic only after the frame's last slot has been captured. On the send side, it takes a snapshot of the memory logic's status and any newly arrived instruction word and data-read result at the end of each frame. It then sends that snapshot byte by byte during the next frame.

Top module: `mem_link_bridge`

## Requirements
- R1: The phase counter is 0 after reset, advances by one every clock and wraps from 7 to 0, so a request arrives every 8 clocks.
- R2: While reset is held, `link_tx`, `req_valid`, `fetch_kick` and every request field read zero.
- R3: The byte received in phase 0 is the flag byte: bit 0 is fetch-restart, bit 1 is fetch-stall and bit 2 is the active-low data-read flag. Bits 7:3 have no effect.
- R4: Phases 1, 2 and 3 carry the instruction address, least significant byte first. Phases 4, 5 and 6 carry the data address the same way. The phase-7 byte has no effect on any field.
- R5: `req_valid` is high for exactly the one clock in phase 0 that follows the capture of a phase-7 byte. The request fields change only at that point and hold for the following 8 clocks.
- R6: `fetch_kick` pulses together with `req_valid` when, and only when, the committed request has fetch-restart set.
- R7: Transmit layout: phase 0 sends the status byte. Phases 1 to 4 send the 32-bit instruction word, least significant byte first. Phases 5 and 6 send the low 16 bits of the data-read result, least significant byte first. Phase 7 sends the status byte again.
- R8: Status bit 0 is started, bit 1 is stopped, bit 2 is instruction-ready and bit 3 is data-ready. Bits 7:4 are zero. Started and stopped are sampled at the clock edge that ends the previous frame.
- R9: A `mem_ivalid` or `mem_dvalid` pulse in any phase of one frame, phase 7 included, is reported in the next frame with its ready bit set. In a frame with nothing new to report, that ready bit is clear and the matching payload bytes are zero.
- R10: If `mem_ivalid` pulses twice within one frame, the next frame carries the word from the later pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the peer |
| rst_n | input | 1 | Synchronous active-low reset, shared with the peer |
| link_rx | input | 8 | Request byte from the peer, one per phase |
| link_tx | output | 8 | Response byte to the peer, one per phase |
| req_valid | output | 1 | One-clock pulse when a new request is committed |
| fetch_kick | output | 1 | One-clock pulse when the committed request asks for a restart |
| req_restart | output | 1 | Committed fetch-restart flag |
| req_stall | output | 1 | Committed fetch-stall flag |
| req_rd_n | output | 1 | Committed active-low data-read flag |
| req_iaddr | output | 24 | Committed instruction address |
| req_daddr | output | 24 | Committed data address |
| mem_started | input | 1 | Memory side reports a fetch in progress |
| mem_stopped | input | 1 | Memory side reports fetch halted |
| mem_ivalid | input | 1 | Pulse: a new instruction word is on `mem_iword` |
| mem_iword | input | 32 | Instruction word |
| mem_dvalid | input | 1 | Pulse: a new data-read result is on `mem_dword` |
| mem_dword | input | 16 | Data-read result |

## Verification
The hardest case to reach is the position of a ready pulse inside a frame. A pulse on the very edge that closes a frame must land in the next snapshot. A pulse in any earlier phase must be held pending until that edge, and the snapshot after it must report nothing. The bench drives one frame for each of the eight phases, placing the instruction pulse in that phase and the data pulse in the mirrored phase. It also drives one frame with two instruction pulses and one empty frame. It predicts every transmitted byte of the following frame arithmetically, and it applies address and flag patterns with junk in the unused flag bits and the reserved slot.

// File: rtl/mem_link_pkg.sv
package mem_link_pkg;
    localparam int BYTE_W      = 8;
    localparam int PHASES      = 8;
    localparam int PH_W        = $clog2(PHASES);
    localparam int IADDR_BYTES = 3;
    localparam int DADDR_BYTES = 3;
    localparam int IWORD_BYTES = 4;
    localparam int DWORD_BYTES = 2;
    localparam int IADDR_W     = IADDR_BYTES * BYTE_W;
    localparam int DADDR_W     = DADDR_BYTES * BYTE_W;
    localparam int IWORD_W     = IWORD_BYTES * BYTE_W;
    localparam int DWORD_W     = DWORD_BYTES * BYTE_W;

    // receive slots
    localparam int PH_FLAGS  = 0;
    localparam int PH_IADDR0 = PH_FLAGS + 1;
    localparam int PH_DADDR0 = PH_IADDR0 + IADDR_BYTES;
    localparam int PH_LAST   = PHASES - 1;

    // transmit slots
    localparam int PH_STATUS = 0;
    localparam int PH_IWORD0 = PH_STATUS + 1;
    localparam int PH_DWORD0 = PH_IWORD0 + IWORD_BYTES;

    // flag byte bits
    localparam int FLG_RESTART = 0;
    localparam int FLG_STALL   = 1;
    localparam int FLG_RD_N    = 2;

    // status byte bits
    localparam int STS_STARTED = 0;
    localparam int STS_STOPPED = 1;
    localparam int STS_IRDY    = 2;
    localparam int STS_DRDY    = 3;

    typedef struct packed {
        logic               restart;
        logic               stall;
        logic               rd_n;
        logic [IADDR_W-1:0] iaddr;
        logic [DADDR_W-1:0] daddr;
    } link_req_t;
endpackage

// File: rtl/link_phase_counter.sv
module link_phase_counter
    import mem_link_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            frame_end
);
    typedef struct packed {
        logic [PH_W-1:0] cnt;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = (st_q.cnt == PH_W'(PH_LAST)) ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase     = st_q.cnt;
    assign frame_end = (st_q.cnt == PH_W'(PH_LAST));
endmodule

// File: rtl/link_rx_assembler.sv
module link_rx_assembler
    import mem_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic              frame_end,
    input  logic [BYTE_W-1:0] rx_byte,
    output link_req_t         req,
    output logic              req_valid,
    output logic              fetch_kick
);
    typedef struct packed {
        link_req_t shadow;
        link_req_t held;
        logic      valid;
        logic      kick;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.kick  = 1'b0;

        if (phase == PH_W'(PH_FLAGS)) begin
            st_d.shadow.restart = rx_byte[FLG_RESTART];
            st_d.shadow.stall   = rx_byte[FLG_STALL];
            st_d.shadow.rd_n    = rx_byte[FLG_RD_N];
        end
        for (int b = 0; b < IADDR_BYTES; b++) begin
            if (phase == PH_W'(PH_IADDR0 + b))
                st_d.shadow.iaddr[b*BYTE_W +: BYTE_W] = rx_byte;
        end
        for (int b = 0; b < DADDR_BYTES; b++) begin
            if (phase == PH_W'(PH_DADDR0 + b))
                st_d.shadow.daddr[b*BYTE_W +: BYTE_W] = rx_byte;
        end

        // reserved slot byte is dropped; commit the assembled frame
        if (frame_end) begin
            st_d.held  = st_q.shadow;
            st_d.valid = 1'b1;
            st_d.kick  = st_q.shadow.restart;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req        = st_q.held;
    assign req_valid  = st_q.valid;
    assign fetch_kick = st_q.kick;
endmodule

// File: rtl/link_tx_serialiser.sv
module link_tx_serialiser
    import mem_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PH_W-1:0]    phase,
    input  logic               frame_end,
    input  logic               started,
    input  logic               stopped,
    input  logic               ivalid,
    input  logic [IWORD_W-1:0] iword,
    input  logic               dvalid,
    input  logic [DWORD_W-1:0] dword,
    output logic [BYTE_W-1:0]  tx_byte
);
    typedef struct packed {
        logic [IWORD_W-1:0] ihold;
        logic               ipend;
        logic [DWORD_W-1:0] dhold;
        logic               dpend;
        logic [BYTE_W-1:0]  f_status;
        logic [IWORD_W-1:0] f_iword;
        logic [DWORD_W-1:0] f_dword;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ivalid) begin
            st_d.ihold = iword;
            st_d.ipend = 1'b1;
        end
        if (dvalid) begin
            st_d.dhold = dword;
            st_d.dpend = 1'b1;
        end

        if (frame_end) begin
            st_d.f_status              = '0;
            st_d.f_status[STS_STARTED] = started;
            st_d.f_status[STS_STOPPED] = stopped;
            st_d.f_status[STS_IRDY]    = st_d.ipend;
            st_d.f_status[STS_DRDY]    = st_d.dpend;
            st_d.f_iword               = st_d.ipend ? st_d.ihold : '0;
            st_d.f_dword               = st_d.dpend ? st_d.dhold : '0;
            st_d.ipend                 = 1'b0;
            st_d.dpend                 = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tx_byte = st_q.f_status;
        for (int b = 0; b < IWORD_BYTES; b++) begin
            if (phase == PH_W'(PH_IWORD0 + b))
                tx_byte = st_q.f_iword[b*BYTE_W +: BYTE_W];
        end
        for (int b = 0; b < DWORD_BYTES; b++) begin
            if (phase == PH_W'(PH_DWORD0 + b))
                tx_byte = st_q.f_dword[b*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/mem_link_bridge.sv
module mem_link_bridge
    import mem_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  link_rx,
    output logic [BYTE_W-1:0]  link_tx,
    output logic               req_valid,
    output logic               fetch_kick,
    output logic               req_restart,
    output logic               req_stall,
    output logic               req_rd_n,
    output logic [IADDR_W-1:0] req_iaddr,
    output logic [DADDR_W-1:0] req_daddr,
    input  logic               mem_started,
    input  logic               mem_stopped,
    input  logic               mem_ivalid,
    input  logic [IWORD_W-1:0] mem_iword,
    input  logic               mem_dvalid,
    input  logic [DWORD_W-1:0] mem_dword
);
    logic [PH_W-1:0] phase_w;
    logic            frame_end_w;
    link_req_t       req_w;

    link_phase_counter i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase_w),
        .frame_end (frame_end_w)
    );

    link_rx_assembler i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase_w),
        .frame_end  (frame_end_w),
        .rx_byte    (link_rx),
        .req        (req_w),
        .req_valid  (req_valid),
        .fetch_kick (fetch_kick)
    );

    link_tx_serialiser i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase_w),
        .frame_end (frame_end_w),
        .started   (mem_started),
        .stopped   (mem_stopped),
        .ivalid    (mem_ivalid),
        .iword     (mem_iword),
        .dvalid    (mem_dvalid),
        .dword     (mem_dword),
        .tx_byte   (link_tx)
    );

    assign req_restart = req_w.restart;
    assign req_stall   = req_w.stall;
    assign req_rd_n    = req_w.rd_n;
    assign req_iaddr   = req_w.iaddr;
    assign req_daddr   = req_w.daddr;
endmodule

// File: rtl/mem_link_bridge_chk.sv
module mem_link_bridge_chk
    import mem_link_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [PH_W-1:0]    phase,
    input logic [BYTE_W-1:0]  link_tx,
    input logic               req_valid,
    input logic               fetch_kick,
    input logic               req_restart,
    input logic               req_stall,
    input logic               req_rd_n,
    input logic [IADDR_W-1:0] req_iaddr,
    input logic [DADDR_W-1:0] req_daddr
);
    logic              past_ok;
    logic [BYTE_W-1:0] stat0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            stat0   <= '0;
        end else begin
            past_ok <= 1'b1;
            if (phase == PH_W'(PH_STATUS)) stat0 <= link_tx;
        end
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> phase == PH_W'($past(phase) + 1'b1)); // R1

    AST_VALID_AT_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> phase == PH_W'(PH_FLAGS)); // R5

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !req_valid) |-> ($stable(req_iaddr) && $stable(req_daddr)
            && $stable(req_restart) && $stable(req_stall) && $stable(req_rd_n))); // R5

    AST_KICK_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_kick |-> (req_valid && req_restart)); // R6

    AST_STATUS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_W'(PH_LAST) |-> link_tx == stat0); // R7

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_W'(PH_STATUS) |-> link_tx[BYTE_W-1:STS_DRDY+1] == '0); // R8

    AST_IWORD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase >= PH_W'(PH_IWORD0) && phase < PH_W'(PH_DWORD0) && !stat0[STS_IRDY])
            |-> link_tx == '0); // R9

    AST_DWORD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase >= PH_W'(PH_DWORD0) && phase < PH_W'(PH_LAST) && !stat0[STS_DRDY])
            |-> link_tx == '0); // R9
endmodule

bind mem_link_bridge mem_link_bridge_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase_w),
    .link_tx     (link_tx),
    .req_valid   (req_valid),
    .fetch_kick  (fetch_kick),
    .req_restart (req_restart),
    .req_stall   (req_stall),
    .req_rd_n    (req_rd_n),
    .req_iaddr   (req_iaddr),
    .req_daddr   (req_daddr)
);

// File: tb/test_mem_link_bridge.sv
`timescale 1ns/1ps
module test_mem_link_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  link_rx = '0;
    logic [7:0]  link_tx;
    logic        req_valid, fetch_kick, req_restart, req_stall, req_rd_n;
    logic [23:0] req_iaddr, req_daddr;
    logic        mem_started = 1'b0, mem_stopped = 1'b0;
    logic        mem_ivalid = 1'b0, mem_dvalid = 1'b0;
    logic [31:0] mem_iword = '0;
    logic [15:0] mem_dword = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  exp_tx [8];
    logic [7:0]  held_flags;
    logic [23:0] held_ia, held_da;
    logic        have_prev;
    logic [7:0]  prev_flags;
    logic [23:0] prev_ia, prev_da;

    always #5 clk = ~clk;

    mem_link_bridge i_mem_link_bridge (
        .clk(clk), .rst_n(rst_n), .link_rx(link_rx), .link_tx(link_tx),
        .req_valid(req_valid), .fetch_kick(fetch_kick),
        .req_restart(req_restart), .req_stall(req_stall), .req_rd_n(req_rd_n),
        .req_iaddr(req_iaddr), .req_daddr(req_daddr),
        .mem_started(mem_started), .mem_stopped(mem_stopped),
        .mem_ivalid(mem_ivalid), .mem_iword(mem_iword),
        .mem_dvalid(mem_dvalid), .mem_dword(mem_dword)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Runs one frame; must be entered just after a negedge in phase 0.
    task automatic run_frame(input logic [7:0] flags, input logic [23:0] ia,
                             input logic [23:0] da, input logic [7:0] rsv,
                             input int ip1, input logic [31:0] w1,
                             input int ip2, input logic [31:0] w2,
                             input int dp, input logic [15:0] dw,
                             input logic st, input logic sp);
        logic [7:0] rq [8];
        logic       iv;
        logic [31:0] wl;
        logic [7:0] sb;
        rq[0] = flags;
        rq[1] = ia[7:0];  rq[2] = ia[15:8];  rq[3] = ia[23:16];
        rq[4] = da[7:0];  rq[5] = da[15:8];  rq[6] = da[23:16];
        rq[7] = rsv;
        for (int p = 0; p < 8; p++) begin
            link_rx     = rq[p];
            mem_ivalid  = (p == ip1) || (p == ip2);
            mem_iword   = (p == ip2) ? w2 : w1;
            mem_dvalid  = (p == dp);
            mem_dword   = dw;
            mem_started = st;
            mem_stopped = sp;
            #1;
            chk($sformatf("R7 R9 tx phase %0d", p), 32'(link_tx), 32'(exp_tx[p]));
            chk($sformatf("R5 R1 valid phase %0d", p), 32'(req_valid), 32'((p == 0) && have_prev));
            if (p == 0 && have_prev) begin
                held_flags = prev_flags; held_ia = prev_ia; held_da = prev_da;
                chk("R6 kick", 32'(fetch_kick), 32'(prev_flags[0]));
            end else begin
                chk("R6 no kick", 32'(fetch_kick), 32'd0);
            end
            chk("R3 flags", {29'd0, req_rd_n, req_stall, req_restart}, {29'd0, held_flags[2:0]});
            chk("R4 iaddr", 32'(req_iaddr), 32'(held_ia));
            chk("R4 daddr", 32'(req_daddr), 32'(held_da));
            @(negedge clk);
        end
        iv = (ip1 >= 0) || (ip2 >= 0);
        wl = (ip2 >= 0) ? w2 : w1;
        sb = {4'd0, dp >= 0, iv, sp, st};
        exp_tx[0] = sb; exp_tx[7] = sb;
        for (int b = 0; b < 4; b++) exp_tx[1+b] = iv ? wl[b*8 +: 8] : 8'd0;
        for (int b = 0; b < 2; b++) exp_tx[5+b] = (dp >= 0) ? dw[b*8 +: 8] : 8'd0;
        prev_flags = flags; prev_ia = ia; prev_da = da; have_prev = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < 8; p++) exp_tx[p] = '0;
        held_flags = '0; held_ia = '0; held_da = '0;
        have_prev = 1'b0; prev_flags = '0; prev_ia = '0; prev_da = '0;

        // R2: reset state while junk is driven
        link_rx = 8'hFF; mem_ivalid = 1'b1; mem_iword = 32'hDEADBEEF;
        mem_started = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 tx", 32'(link_tx), 32'd0);
        chk("R2 valid", 32'(req_valid), 32'd0);
        chk("R2 kick", 32'(fetch_kick), 32'd0);
        chk("R2 iaddr", 32'(req_iaddr), 32'd0);
        chk("R2 daddr", 32'(req_daddr), 32'd0);
        chk("R2 flags", {29'd0, req_rd_n, req_stall, req_restart}, 32'd0);
        mem_ivalid = 1'b0; mem_started = 1'b0;
        rst_n = 1'b1;

        // sweep pulse position over all phases, flag combos over all values
        for (int k = 0; k < 8; k++) begin
            run_frame({5'(k * 7 + 3), 3'(k)},
                      24'h10_2030 + 24'(k) * 24'h01_0305,
                      24'hF0_E0D0 - 24'(k) * 24'h02_0107,
                      8'(8'hA5 ^ k),
                      k, 32'h1122_3344 + 32'(k) * 32'h0101_0101,
                      -1, 32'd0,
                      7 - k, 16'h5A00 + 16'(k) * 16'h0111,
                      k[0], k[1]);
        end
        // R10: two instruction pulses in one frame
        run_frame(8'h05, 24'hABCDEF, 24'h123456, 8'hFF,
                  1, 32'hCAFE_0001, 6, 32'hBEEF_0002, -1, 16'd0, 1'b1, 1'b0);
        // R9: empty frame, ready bits must clear
        run_frame(8'h00, 24'h000001, 24'hFFFFFE, 8'h00,
                  -1, 32'd0, -1, 32'd0, -1, 16'd0, 1'b0, 1'b1);
        run_frame(8'hF8, 24'h7F7F7F, 24'h808080, 8'h3C,
                  7, 32'h0F0F_F0F0, -1, 32'd0, 0, 16'hC3C3, 1'b1, 1'b1);
        run_frame(8'h01, 24'h000000, 24'h000000, 8'h00,
                  -1, 32'd0, -1, 32'd0, -1, 16'd0, 1'b0, 1'b0);
        mem_ivalid = 1'b0; mem_dvalid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule